// File: doc/BRIEF.md
# BT.656 Stream Formatter

The formatter turns a video payload source and per-line timing flags into an 8-bit byte stream. It emits one byte on every line-locked clock. In the framed data types, every line opens with an end-of-active-video code. Horizontal blanking filler follows, then a start-of-active-video code, then an active region of fixed length. Each timing code is four bytes: the preamble FFh, 00h, 00h and then a status byte. The status byte carries the field flag, the vertical-blanking flag, the H flag and four protection bits. In the raw data type no codes are sent. The payload is passed only inside a window of the line whose limits come from an 8-bit start register and an 8-bit stop register; every other byte is 00h.

The data type, the field flag, the vertical-blanking flag and the raw window registers are all sampled once per line, on the clock that starts the line. They hold for the whole line, so a change mid-line takes effect at the next line. The line is a fixed `LINE_LEN` clocks long. The active region is `ACTIVE_LEN` clocks, and the raw window limits are scaled by `RAW_SCALE`.

The sequencer is a state machine with six states. ST_IDLE exists only in reset. ST_EAV, ST_HBLANK, ST_SAV and ST_ACTIVE make up a framed line, and ST_RAW fills a whole raw line. The transitions are:
- ST_IDLE → ST_EAV or ST_RAW, on the first clock after reset.
- ST_EAV → ST_HBLANK, after the fourth code byte.
- ST_HBLANK → ST_SAV, four clocks before the active region.
- ST_SAV → ST_ACTIVE.
- ST_ACTIVE or ST_RAW → ST_EAV or ST_RAW, at the line wrap. The choice follows the data type sampled there.

Top module: `bt656_framer`

## Requirements
- R1: The fourth byte of each code has bit 7 = 1, bit 6 = F, bit 5 = V and bit 4 = H. Bits 3..0 are V^H, F^H, F^V and F^V^H. The first three bytes are FFh, 00h, 00h.
- R2: At line position 0, the end code (H = 1) starts. The start code (H = 0) fills the four positions just before the active region.
- R3: F and V in both codes of a line are the field_i and vblank_i values sampled at that line's start. Changes later in the line are ignored.
- R4: In the framed types, each line lasts LINE_LEN clocks and the active region fills its last ACTIVE_LEN positions.
- R5: For data type 6 or 15, every active byte equals the data_i value of that clock.
- R6: For data types other than 6, 7 and 15, an active byte equals data_i when data_vld_i is 1, and is 00h otherwise.
- R7: Positions 4 up to the start code alternate 80h and 10h, beginning with 80h.
- R8: Data type 7 sends no codes. The byte at position p is data_i when start*RAW_SCALE ≤ p < stop*RAW_SCALE, and is 00h otherwise. The window is empty when start ≥ stop.
- R9: A change of dtype_i or of the raw window registers takes effect only at the next line start.
- R10: vid_o is 00h in reset and on the first clock after it. The byte for line position 0 of the first line appears after the second rising edge following reset release. Each byte appears one clock after its inputs are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Line-locked clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| dtype_i | input | 4 | Data type select (6, 15 YUV; 7 raw; others sliced) |
| field_i | input | 1 | Field flag, 0 first field, 1 second field |
| vblank_i | input | 1 | Vertical blanking flag, 1 in blanking lines |
| raw_start_i | input | 8 | Raw window start, in RAW_SCALE units |
| raw_stop_i | input | 8 | Raw window stop, in RAW_SCALE units |
| data_i | input | 8 | Payload byte |
| data_vld_i | input | 1 | Payload valid, used by sliced types |
| vid_o | output | 8 | Formatted byte stream |

## Verification
The bench goes after F, V and data type being toggled in the middle of a line. A design that samples them live would put the wrong flags into the start code, or switch framing halfway through the line. It also runs raw windows that are empty, inverted and wider than the line. A comparator with an off-by-one end, or one that wraps, would pass or drop a byte at the edge of the window. Every byte of the line is checked against a position model. A one-clock shift in code placement, blanking phase or active length therefore shows up as a mismatch at the region edges. A wrong protection-bit term shows up in the status bytes across all four F/V combinations.

// File: rtl/bt656_pkg.sv
package bt656_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EAV,
        ST_HBLANK,
        ST_SAV,
        ST_ACTIVE,
        ST_RAW
    } fmt_state_e;

    typedef enum logic [1:0] {
        KIND_YUV,
        KIND_SLICED,
        KIND_RAW
    } dkind_e;

    localparam logic [7:0] BYTE_ONES  = 8'hFF;
    localparam logic [7:0] BYTE_ZERO  = 8'h00;
    localparam logic [7:0] BLANK_EVEN = 8'h80;
    localparam logic [7:0] BLANK_ODD  = 8'h10;

    function automatic dkind_e classify(input logic [3:0] dt);
        dkind_e k;
        if (dt == 4'd6 || dt == 4'd15) begin
            k = KIND_YUV;
        end else if (dt == 4'd7) begin
            k = KIND_RAW;
        end else begin
            k = KIND_SLICED;
        end
        return k;
    endfunction

endpackage

// File: rtl/bt656_pos_counter.sv
module bt656_pos_counter #(
    parameter int LINE_LEN = 1716,
    parameter int POS_W    = 11
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    output logic [POS_W-1:0] pos_o,
    output logic             wrap_o
);
    localparam logic [POS_W-1:0] LAST = POS_W'(LINE_LEN - 1);

    logic [POS_W-1:0] pos_q;

    // Reset parks on the last position so the first edge opens a line.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pos_q <= LAST;
        end else if (pos_q == LAST) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_q + 1'b1;
        end
    end

    assign pos_o  = pos_q;
    assign wrap_o = (pos_q == LAST);
endmodule

// File: rtl/bt656_ref_code.sv
module bt656_ref_code (
    input  logic       f_i,
    input  logic       v_i,
    input  logic       h_i,
    output logic [7:0] code_o
);
    always_comb begin
        code_o = {1'b1, f_i, v_i, h_i,
                  v_i ^ h_i,
                  f_i ^ h_i,
                  f_i ^ v_i,
                  f_i ^ v_i ^ h_i};
    end
endmodule

// File: rtl/bt656_raw_window.sv
module bt656_raw_window #(
    parameter int POS_W     = 11,
    parameter int RAW_SCALE = 8
) (
    input  logic [POS_W-1:0] pos_i,
    input  logic [7:0]       start_i,
    input  logic [7:0]       stop_i,
    output logic             inside_o
);
    localparam int SCALE_W = $clog2(RAW_SCALE + 1);
    localparam int RW      = 8 + SCALE_W;
    localparam int WIN_W   = (POS_W > RW) ? POS_W : RW;

    logic [WIN_W-1:0] lo;
    logic [WIN_W-1:0] hi;
    logic [WIN_W-1:0] p;

    always_comb begin
        lo       = WIN_W'(start_i) * WIN_W'(RAW_SCALE);
        hi       = WIN_W'(stop_i)  * WIN_W'(RAW_SCALE);
        p        = WIN_W'(pos_i);
        inside_o = (p >= lo) && (p < hi);
    end
endmodule

// File: rtl/bt656_framer.sv
module bt656_framer
    import bt656_pkg::*;
#(
    parameter int LINE_LEN   = 1716,
    parameter int ACTIVE_LEN = 1440,
    parameter int RAW_SCALE  = 8
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [3:0] dtype_i,
    input  logic       field_i,
    input  logic       vblank_i,
    input  logic [7:0] raw_start_i,
    input  logic [7:0] raw_stop_i,
    input  logic [7:0] data_i,
    input  logic       data_vld_i,
    output logic [7:0] vid_o
);
    localparam int POS_W     = $clog2(LINE_LEN);
    localparam int SAV_FIRST = LINE_LEN - ACTIVE_LEN - 4;
    localparam int ACT_FIRST = LINE_LEN - ACTIVE_LEN;

    localparam logic [POS_W-1:0] P_ZERO     = '0;
    localparam logic [POS_W-1:0] P_EAV_LAST = POS_W'(3);
    localparam logic [POS_W-1:0] P_HB_LAST  = POS_W'(SAV_FIRST - 1);
    localparam logic [POS_W-1:0] P_SAV_HEAD = POS_W'(SAV_FIRST);
    localparam logic [POS_W-1:0] P_SAV_LAST = POS_W'(ACT_FIRST - 1);

    fmt_state_e       state_q;
    fmt_state_e       state_d;
    logic [POS_W-1:0] pos_q;
    logic             line_go;

    dkind_e           kind_line;
    logic             f_line;
    logic             v_line;
    logic [7:0]       raw_start_line;
    logic [7:0]       raw_stop_line;

    logic [7:0]       ref_codes [2];
    logic             raw_in;
    logic [7:0]       byte_d;
    logic [7:0]       vid_q;

    bt656_pos_counter #(
        .LINE_LEN (LINE_LEN),
        .POS_W    (POS_W)
    ) u_pos (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pos_o  (pos_q),
        .wrap_o (line_go)
    );

    // Per-line configuration, captured on the clock that starts a line.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            kind_line      <= KIND_YUV;
            f_line         <= 1'b0;
            v_line         <= 1'b0;
            raw_start_line <= '0;
            raw_stop_line  <= '0;
        end else if (line_go) begin
            kind_line      <= classify(dtype_i);
            f_line         <= field_i;
            v_line         <= vblank_i;
            raw_start_line <= raw_start_i;
            raw_stop_line  <= raw_stop_i;
        end
    end

    // Index 0 builds the end code (H = 1), index 1 the start code (H = 0).
    for (genvar g = 0; g < 2; g++) begin : g_code
        bt656_ref_code u_code (
            .f_i    (f_line),
            .v_i    (v_line),
            .h_i    ((g == 0) ? 1'b1 : 1'b0),
            .code_o (ref_codes[g])
        );
    end

    bt656_raw_window #(
        .POS_W     (POS_W),
        .RAW_SCALE (RAW_SCALE)
    ) u_window (
        .pos_i    (pos_q),
        .start_i  (raw_start_line),
        .stop_i   (raw_stop_line),
        .inside_o (raw_in)
    );

    // State register.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        if (line_go) begin
            state_d = (classify(dtype_i) == KIND_RAW) ? ST_RAW : ST_EAV;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_IDLE;
                ST_EAV:    if (pos_q == P_EAV_LAST) state_d = ST_HBLANK;
                ST_HBLANK: if (pos_q == P_HB_LAST)  state_d = ST_SAV;
                ST_SAV:    if (pos_q == P_SAV_LAST) state_d = ST_ACTIVE;
                ST_ACTIVE: state_d = ST_ACTIVE;
                ST_RAW:    state_d = ST_RAW;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // Output byte selection.
    always_comb begin
        byte_d = BYTE_ZERO;
        unique case (state_q)
            ST_IDLE: byte_d = BYTE_ZERO;
            ST_EAV: begin
                if (pos_q == P_ZERO) begin
                    byte_d = BYTE_ONES;
                end else if (pos_q == P_EAV_LAST) begin
                    byte_d = ref_codes[0];
                end else begin
                    byte_d = BYTE_ZERO;
                end
            end
            ST_HBLANK: byte_d = pos_q[0] ? BLANK_ODD : BLANK_EVEN;
            ST_SAV: begin
                if (pos_q == P_SAV_HEAD) begin
                    byte_d = BYTE_ONES;
                end else if (pos_q == P_SAV_LAST) begin
                    byte_d = ref_codes[1];
                end else begin
                    byte_d = BYTE_ZERO;
                end
            end
            ST_ACTIVE: begin
                if (kind_line == KIND_SLICED && !data_vld_i) begin
                    byte_d = BYTE_ZERO;
                end else begin
                    byte_d = data_i;
                end
            end
            ST_RAW:  byte_d = raw_in ? data_i : BYTE_ZERO;
            default: byte_d = BYTE_ZERO;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            vid_q <= BYTE_ZERO;
        end else begin
            vid_q <= byte_d;
        end
    end

    assign vid_o = vid_q;
endmodule

// File: rtl/bt656_framer_chk.sv
module bt656_framer_chk
    import bt656_pkg::*;
#(
    parameter int LINE_LEN  = 1716,
    parameter int POS_W     = 11,
    parameter int ACT_FIRST = 276
) (
    input logic             clk_i,
    input logic             rst_ni,
    input fmt_state_e       state_q,
    input logic [POS_W-1:0] pos_q,
    input logic             f_line,
    input logic             v_line,
    input dkind_e           kind_line,
    input logic             data_vld_i,
    input logic [7:0]       vid_o
);
    localparam logic [POS_W-1:0] LAST  = POS_W'(LINE_LEN - 1);
    localparam logic [POS_W-1:0] AFIRS = POS_W'(ACT_FIRST);

    AST_EAV_PROTECTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_HBLANK && $past(state_q) == ST_EAV) |->
        (vid_o[7] && vid_o[3] == (vid_o[5] ^ vid_o[4]) && vid_o[2] == (vid_o[6] ^ vid_o[4])
         && vid_o[1] == (vid_o[6] ^ vid_o[5]) && vid_o[0] == (vid_o[6] ^ vid_o[5] ^ vid_o[4]))); // R1

    AST_EAV_H_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_HBLANK && $past(state_q) == ST_EAV) |-> vid_o[4]); // R2

    AST_SAV_H_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_ACTIVE && $past(state_q) == ST_SAV) |-> (vid_o[7] && !vid_o[4])); // R2

    AST_FV_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pos_q != LAST) |=> ($stable(f_line) && $stable(v_line))); // R3

    AST_ACTIVE_SPAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_ACTIVE) |-> (pos_q >= AFIRS)); // R4

    AST_ACTIVE_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_ACTIVE && pos_q == LAST) |=> (state_q == ST_EAV || state_q == ST_RAW)); // R4

    AST_SLICED_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_ACTIVE && kind_line == KIND_SLICED && !data_vld_i) |=> (vid_o == 8'h00)); // R6

    AST_BLANK_BYTES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_HBLANK) |=> (vid_o == 8'h80 || vid_o == 8'h10)); // R7

    AST_RAW_WHOLE_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_RAW && pos_q != LAST) |=> (state_q == ST_RAW)); // R8
endmodule

bind bt656_framer bt656_framer_chk #(
    .LINE_LEN  (LINE_LEN),
    .POS_W     (POS_W),
    .ACT_FIRST (ACT_FIRST)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .state_q    (state_q),
    .pos_q      (pos_q),
    .f_line     (f_line),
    .v_line     (v_line),
    .kind_line  (kind_line),
    .data_vld_i (data_vld_i),
    .vid_o      (vid_o)
);

// File: tb/test_bt656_framer.sv
module test_bt656_framer;
    localparam int L     = 40;
    localparam int A     = 16;
    localparam int S     = 2;
    localparam int LINES = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] dtype = 4'd15;
    logic       field = 1'b0;
    logic       vblank = 1'b0;
    logic [7:0] raw_start = '0;
    logic [7:0] raw_stop = '0;
    logic [7:0] data = '0;
    logic       data_vld = 1'b0;
    logic [7:0] vid;

    bt656_framer #(
        .LINE_LEN   (L),
        .ACTIVE_LEN (A),
        .RAW_SCALE  (S)
    ) i_bt656_framer (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .dtype_i     (dtype),
        .field_i     (field),
        .vblank_i    (vblank),
        .raw_start_i (raw_start),
        .raw_stop_i  (raw_stop),
        .data_i      (data),
        .data_vld_i  (data_vld),
        .vid_o       (vid)
    );

    always #5 clk = ~clk;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    int n      = 0;

    // Line model: 0 yuv, 1 sliced, 2 raw
    int m_kind = 0;
    bit m_f    = 1'b0;
    bit m_v    = 1'b0;
    int m_rs   = 0;
    int m_re   = 0;

    int dts [8] = '{15, 6, 0, 7, 3, 7, 14, 7};

    function automatic int kind_of(input logic [3:0] dt);
        if (dt == 4'd6 || dt == 4'd15) return 0;
        if (dt == 4'd7) return 2;
        return 1;
    endfunction

    function automatic logic [7:0] xy(input bit f, input bit v, input bit h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    task automatic check(input logic [7:0] exp, input string req);
        n_run++;
        if (vid !== exp) begin
            n_fail++;
            $display("FAIL %s at edge %0d: got %02h expected %02h", req, n, vid, exp);
        end
    endtask

    task automatic step();
        logic [7:0] exp;
        string      req;
        int         p;
        n = n + 1;
        if (n == 1) begin
            exp = 8'h00; req = "R10";
        end else begin
            p = (n - 2) % L;
            if (m_kind == 2) begin
                exp = (p >= m_rs * S && p < m_re * S) ? data : 8'h00;
                req = "R8 R9";
            end else if (p == 0 || p == L - A - 4) begin
                exp = 8'hFF; req = "R2 R4";
            end else if (p == 3) begin
                exp = xy(m_f, m_v, 1'b1); req = "R1 R2 R3";
            end else if (p == L - A - 1) begin
                exp = xy(m_f, m_v, 1'b0); req = "R1 R2 R3";
            end else if (p < 3 || (p > L - A - 4 && p < L - A)) begin
                exp = 8'h00; req = "R1 R4";
            end else if (p < L - A - 4) begin
                exp = (p % 2 == 0) ? 8'h80 : 8'h10; req = "R7";
            end else if (m_kind == 0) begin
                exp = data; req = "R5 R4 R9";
            end else begin
                exp = data_vld ? data : 8'h00; req = "R6 R4 R9";
            end
        end
        if ((n - 1) % L == 0) begin
            m_kind = kind_of(dtype);
            m_f    = field;
            m_v    = vblank;
            m_rs   = int'(raw_start);
            m_re   = int'(raw_stop);
        end
        @(posedge clk);
        #1;
        check(exp, req);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL R10 watchdog: got running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(8'h00, "R10 reset");
        rst_n = 1'b1;
        for (int e = 1; e <= LINES * L + 1; e++) begin
            int ph;
            int k;
            ph = (e - 1) % L;
            k  = (e - 1) / L;
            if (ph == 0) begin
                dtype  = 4'(dts[k % 8]);
                field  = k[0];
                vblank = k[1];
                raw_start = 8'((k * 5) % 9);
                raw_stop  = 8'((k * 5) % 9 + 2 + (k % 6));
                if (k % 7 == 3) begin
                    raw_start = 8'd14; raw_stop = 8'd3;
                end
                if (k % 7 == 5) begin
                    raw_start = 8'd0; raw_stop = 8'd255;
                end
            end else if (ph == 13) begin
                field     = ~field;
                vblank    = ~vblank;
                dtype     = dtype ^ 4'b0001;
                raw_start = 8'd0;
                raw_stop  = 8'hFF;
            end
            data     = 8'((e * 37 + 11) % 256);
            data_vld = (e % 3) != 0;
            step();
        end
        done = 1'b1;
        summary();
        $finish;
    end
endmodule